// File: doc/BRIEF.md
# Oversampled Video Input Phase Aligner

This block takes in a slow parallel digital video bus through a fast oversampling clock. It drives the slow reference clock back to the video source by dividing the fast clock. The colour, sync and display-enable inputs are asynchronous to the fast clock. Each input passes through a two-flop synchronizer and then through a tap delay line whose length is set at run time. Sync and display-enable share one tap. The colour data uses a second tap. One sample is taken in every 16 or 32 fast clocks, depending on the pixel rate.

After reset the source may come up at any of four phases of its reference clock relative to display-enable. Software therefore moves the effective sampling instant with the two taps until the capture is clean. The tap and pixel-rate settings are latched only on a rising edge of the delayed vertical sync, so one frame is always captured at a single phase. The block also marks the first captured pixel of each frame on which display-enable is high.

Top module: `vcap_aligner`

## Requirements
- R1: `src_clk_o` is low during reset. After reset it toggles every 4 fast clocks, which gives a period of 8 fast clocks.
- R2: On a cycle where `pix_valid_o` is high, `pix_o` holds `{red_i, grn_i, blu_i}`, with red in the top 4 bits and blue in the bottom 4. The value is the one present at the fast clock edge `2 + Td` edges before the edge that raised `pix_valid_o`. Td is the active data tap.
- R3: On a cycle where `pix_valid_o` is high, `hsync_o`, `vsync_o` and `de_o` show the inputs present `2 + Ts` edges before that edge. Ts is the active sync tap. These outputs and `pix_o` hold their values on every cycle where `pix_valid_o` is low.
- R4: `pix_valid_o` is a single-cycle pulse. When the active pixel-rate setting is 1 (fast pixels), consecutive pulses are exactly 16 fast clocks apart.
- R5: When the active pixel-rate setting is 0 (slow pixels), consecutive `pix_valid_o` pulses are exactly 32 fast clocks apart.
- R6: Both taps cover the full range 0 to 15, and each tap works independently of the other (for example sync 15 with data 0, and sync 0 with data 15).
- R7: The configuration inputs `cfg_hi_res_i`, `cfg_sync_tap_i` and `cfg_data_tap_i` are latched only on a rising edge of the delayed vertical sync. Changing them at any other time has no effect on the captured outputs or on the pulse spacing.
- R8: `sof_o` pulses together with the first `pix_valid_o` after a vertical sync rise on which `de_o` is high. It pulses at no other time.
- R9: While reset is held, `pix_valid_o`, `sof_o`, `pix_o`, `de_o` and `src_clk_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Oversampling clock (8x the reference clock) |
| rst_n_i | input | 1 | Synchronous active-low reset |
| cfg_hi_res_i | input | 1 | Pixel-rate select: 1 = one sample per 16 clocks, 0 = one per 32 |
| cfg_sync_tap_i | input | 4 | Delay tap for sync and display-enable, 0 to 15 |
| cfg_data_tap_i | input | 4 | Delay tap for colour data, 0 to 15 |
| red_i | input | 4 | Red channel from the source |
| grn_i | input | 4 | Green channel from the source |
| blu_i | input | 4 | Blue channel from the source |
| hsync_i | input | 1 | Horizontal sync from the source |
| vsync_i | input | 1 | Vertical sync from the source |
| de_i | input | 1 | Display-enable from the source |
| src_clk_o | output | 1 | Reference clock driven to the source |
| pix_o | output | 12 | Captured pixel word |
| pix_valid_o | output | 1 | One-clock strobe for a new sample |
| hsync_o | output | 1 | Captured horizontal sync |
| vsync_o | output | 1 | Captured vertical sync |
| de_o | output | 1 | Captured display-enable |
| sof_o | output | 1 | First active pixel of the frame |

## Verification
An input that is present at fast edge j shows up at the outputs on the `pix_valid_o` edge m only when m = j + 2 + tap. The bench keeps a 64-deep history of what it drove at each edge and looks up entry m-2-tap for each pulse. It samples the outputs on the falling edge that follows that rising edge. New settings take effect a few cycles after the delayed vertical sync rises. For that reason the bench suspends its checks across each sync window and starts again only once the new taps have settled. Pulse spacing and the reference clock toggles are measured as edge-count differences between consecutive events.

// File: rtl/vcap_pkg.sv
// Shared constants and types for the video phase aligner.
// Assumes power-of-two tap depth; the widths below feed every submodule.
package vcap_pkg;
    localparam int VCAP_COLOR_W   = 4;
    localparam int VCAP_TAP_DEPTH = 16;
    localparam int VCAP_TAP_W     = $clog2(VCAP_TAP_DEPTH);
    localparam int VCAP_PIX_W     = 3 * VCAP_COLOR_W;

    // Phase and rate settings that are latched once per frame.
    typedef struct packed {
        logic                  hi_res;
        logic [VCAP_TAP_W-1:0] sync_tap;
        logic [VCAP_TAP_W-1:0] data_tap;
    } vcap_cfg_t;

    // Control signals that share the sync tap.
    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } vcap_ctl_t;
endpackage

// File: rtl/vcap_sync2.sv
// Two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent; multi-bit skew is absorbed by sampling later.
module vcap_sync2 #(
    parameter int W = 1
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    // Two register stages into the fast clock domain.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/vcap_tapdelay.sv
// Programmable delay line: output is the input delayed by tap_i clocks (0..DEPTH-1).
// Assumes DEPTH >= 2 and TAP_W = clog2(DEPTH); tap 0 passes the input through.
module vcap_tapdelay #(
    parameter int W     = 1,
    parameter int DEPTH = 16,
    parameter int TAP_W = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [TAP_W-1:0] tap_i,
    input  logic [W-1:0]     d_i,
    output logic [W-1:0]     q_o
);
    localparam int STAGES = DEPTH - 1;

    logic [STAGES-1:0][W-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_single
            // One stage: a plain register.
            always_ff @(posedge clk_i) begin
                if (!rst_n_i) stg_q <= '0;
                else          stg_q[0] <= d_i;
            end
        end else begin : g_chain
            // Shift chain: stage i holds the input from i+1 clocks ago.
            always_ff @(posedge clk_i) begin
                if (!rst_n_i) stg_q <= '0;
                else          stg_q <= {stg_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    // Tap select: zero bypasses the chain.
    always_comb begin
        q_o = d_i;
        if (tap_i != '0) q_o = stg_q[tap_i - 1'b1];
    end
endmodule

// File: rtl/vcap_clkgen.sv
// Divides the fast clock to make the source reference clock and the sample strobe.
// Assumes SLOT_HI and SLOT_LO are powers of two, with SLOT_LO >= SLOT_HI >= 2.
module vcap_clkgen #(
    parameter int DIV_HALF = 4,
    parameter int SLOT_HI  = 16,
    parameter int SLOT_LO  = 32
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic hi_res_i,
    output logic ref_clk_o,
    output logic strobe_o
);
    localparam int DIV_W  = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int SLOT_W = $clog2(SLOT_LO);
    localparam int HI_W   = $clog2(SLOT_HI);

    logic [DIV_W-1:0]  div_q;
    logic [SLOT_W-1:0] slot_q;

    // Reference clock: toggle the register each time the half-period counter wraps.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            div_q     <= '0;
            ref_clk_o <= 1'b0;
        end else if (div_q == DIV_W'(DIV_HALF - 1)) begin
            div_q     <= '0;
            ref_clk_o <= ~ref_clk_o;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Slot counter: free-running across the slow pixel period.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) slot_q <= '0;
        else          slot_q <= slot_q + 1'b1;
    end

    // Strobe: slot zero of each fast or slow pixel period.
    always_comb begin
        if (hi_res_i) strobe_o = (slot_q[HI_W-1:0] == '0);
        else          strobe_o = (slot_q == '0);
    end

    assert_refclk_half_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ref_clk_o != $past(ref_clk_o)) |=> (ref_clk_o == $past(ref_clk_o)));

    assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        strobe_o |=> !strobe_o);
endmodule

// File: rtl/vcap_aligner.sv
// Top: captures a slow parallel video bus with a fast oversampling clock.
// Synchronizes the inputs, delays sync/DE and colour by separate taps, samples once per
// pixel period, and latches new settings only on a rising edge of the delayed vsync.
// Assumes the inputs are asynchronous and change no faster than the pixel period.
module vcap_aligner
    import vcap_pkg::*;
#(
    parameter int DIV_HALF = 4,
    parameter int SLOT_HI  = 16,
    parameter int SLOT_LO  = 32
) (
    input  logic                    clk_fast_i,
    input  logic                    rst_n_i,
    input  logic                    cfg_hi_res_i,
    input  logic [VCAP_TAP_W-1:0]   cfg_sync_tap_i,
    input  logic [VCAP_TAP_W-1:0]   cfg_data_tap_i,
    input  logic [VCAP_COLOR_W-1:0] red_i,
    input  logic [VCAP_COLOR_W-1:0] grn_i,
    input  logic [VCAP_COLOR_W-1:0] blu_i,
    input  logic                    hsync_i,
    input  logic                    vsync_i,
    input  logic                    de_i,
    output logic                    src_clk_o,
    output logic [VCAP_PIX_W-1:0]   pix_o,
    output logic                    pix_valid_o,
    output logic                    hsync_o,
    output logic                    vsync_o,
    output logic                    de_o,
    output logic                    sof_o
);
    vcap_cfg_t             act_q;
    vcap_ctl_t             ctl_raw, ctl_sync, ctl_dly;
    logic [VCAP_PIX_W-1:0] pix_sync, pix_dly;
    logic                  strobe;
    logic                  vs_prev_q, vs_rise, armed_q;

    assign ctl_raw = '{hs: hsync_i, vs: vsync_i, de: de_i};

    vcap_clkgen #(.DIV_HALF(DIV_HALF), .SLOT_HI(SLOT_HI), .SLOT_LO(SLOT_LO)) u_clkgen (
        .clk_i     (clk_fast_i),
        .rst_n_i   (rst_n_i),
        .hi_res_i  (act_q.hi_res),
        .ref_clk_o (src_clk_o),
        .strobe_o  (strobe)
    );

    vcap_sync2 #(.W(VCAP_PIX_W)) u_sync_pix (
        .clk_i (clk_fast_i), .rst_n_i (rst_n_i),
        .d_i   ({red_i, grn_i, blu_i}), .q_o (pix_sync)
    );

    vcap_sync2 #(.W(3)) u_sync_ctl (
        .clk_i (clk_fast_i), .rst_n_i (rst_n_i),
        .d_i   (ctl_raw), .q_o (ctl_sync)
    );

    vcap_tapdelay #(.W(VCAP_PIX_W), .DEPTH(VCAP_TAP_DEPTH), .TAP_W(VCAP_TAP_W)) u_dly_pix (
        .clk_i (clk_fast_i), .rst_n_i (rst_n_i),
        .tap_i (act_q.data_tap), .d_i (pix_sync), .q_o (pix_dly)
    );

    vcap_tapdelay #(.W(3), .DEPTH(VCAP_TAP_DEPTH), .TAP_W(VCAP_TAP_W)) u_dly_ctl (
        .clk_i (clk_fast_i), .rst_n_i (rst_n_i),
        .tap_i (act_q.sync_tap), .d_i (ctl_sync), .q_o (ctl_dly)
    );

    // Frame boundary: rising edge of the delayed vertical sync.
    always_ff @(posedge clk_fast_i) begin
        if (!rst_n_i) vs_prev_q <= 1'b0;
        else          vs_prev_q <= ctl_dly.vs;
    end
    assign vs_rise = ctl_dly.vs & ~vs_prev_q;

    // Active settings: copied from the inputs only at a frame boundary.
    always_ff @(posedge clk_fast_i) begin
        if (!rst_n_i) begin
            act_q <= '0;
        end else if (vs_rise) begin
            act_q <= '{hi_res: cfg_hi_res_i, sync_tap: cfg_sync_tap_i,
                       data_tap: cfg_data_tap_i};
        end
    end

    // Sample registers: load the delayed bus once per pixel period.
    always_ff @(posedge clk_fast_i) begin
        if (!rst_n_i) begin
            pix_o   <= '0;
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
            de_o    <= 1'b0;
        end else if (strobe) begin
            pix_o   <= pix_dly;
            hsync_o <= ctl_dly.hs;
            vsync_o <= ctl_dly.vs;
            de_o    <= ctl_dly.de;
        end
    end

    // Valid strobe: one clock per captured sample.
    always_ff @(posedge clk_fast_i) begin
        if (!rst_n_i) pix_valid_o <= 1'b0;
        else          pix_valid_o <= strobe;
    end

    // Start-of-frame arming: set at vsync rise, cleared by the first active sample.
    always_ff @(posedge clk_fast_i) begin
        if (!rst_n_i)                          armed_q <= 1'b0;
        else if (vs_rise)                      armed_q <= 1'b1;
        else if (strobe && ctl_dly.de)         armed_q <= 1'b0;
    end

    // Start-of-frame flag: marks the first active sample after arming.
    always_ff @(posedge clk_fast_i) begin
        if (!rst_n_i) sof_o <= 1'b0;
        else          sof_o <= strobe & ctl_dly.de & armed_q & ~vs_rise;
    end

    assert_valid_pulse_R4: assert property (@(posedge clk_fast_i) disable iff (!rst_n_i)
        pix_valid_o |=> !pix_valid_o);

    assert_hold_between_R3: assert property (@(posedge clk_fast_i) disable iff (!rst_n_i)
        !pix_valid_o |-> $stable({hsync_o, vsync_o, de_o, pix_o}));

    assert_cfg_frame_only_R7: assert property (@(posedge clk_fast_i) disable iff (!rst_n_i)
        !vs_rise |=> $stable(act_q));

    assert_sof_on_active_R8: assert property (@(posedge clk_fast_i) disable iff (!rst_n_i)
        sof_o |-> (pix_valid_o && de_o));
endmodule

// File: tb/vcap_aligner_bench.sv
module vcap_aligner_bench;
    import vcap_pkg::*;
    localparam int PW = VCAP_PIX_W;
    localparam int TW = VCAP_TAP_W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cfg_hi = 1'b0;
    logic [TW-1:0] cfg_st = '0, cfg_dt = '0;
    logic [3:0]    red = '0, grn = '0, blu = '0;
    logic          hs = 1'b0, vs = 1'b0, de = 1'b0;
    logic          src_clk, pv, hs_o, vs_o, de_o, sof;
    logic [PW-1:0] pix;

    vcap_aligner u_vcap_aligner (
        .clk_fast_i (clk), .rst_n_i (rst_n), .cfg_hi_res_i (cfg_hi),
        .cfg_sync_tap_i (cfg_st), .cfg_data_tap_i (cfg_dt),
        .red_i (red), .grn_i (grn), .blu_i (blu),
        .hsync_i (hs), .vsync_i (vs), .de_i (de),
        .src_clk_o (src_clk), .pix_o (pix), .pix_valid_o (pv),
        .hsync_o (hs_o), .vsync_o (vs_o), .de_o (de_o), .sof_o (sof)
    );

    int errs = 0, checks = 0;
    bit done = 0;
    logic [PW+2:0] hist [64];
    longint m = 0, last_v = -1, last_t = -1;
    int ks = 0, kd = 0;
    bit hi = 0, chk_en = 0, armed_b = 0, de_en = 0, vs_drv = 0, prev_src = 0;
    logic [PW+2:0] last_out;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d (edge %0d)", req, what, act, exp, m);
        end
    endtask

    // One fast cycle: check outputs of the edge just passed, then drive the next inputs.
    task automatic step();
        logic [PW+2:0] ed, es;
        bit exp_sof;
        @(negedge clk);
        m++;
        if (rst_n) begin
            if (src_clk !== prev_src) begin
                if (last_t >= 0) chk((m - last_t) == 4, "R1", "ref toggle gap", m - last_t, 4);
                last_t = m;
                prev_src = src_clk;
            end
            if (chk_en) begin
                if (pv) begin
                    ed = hist[int'((m - 2 - kd) % 64)];
                    es = hist[int'((m - 2 - ks) % 64)];
                    chk(pix == ed[PW-1:0], "R2", "pixel word", pix, ed[PW-1:0]);
                    chk({hs_o, vs_o, de_o} == es[PW+2:PW], "R3", "sync/de",
                        {hs_o, vs_o, de_o}, es[PW+2:PW]);
                    exp_sof = armed_b && es[PW];
                    chk(sof == exp_sof, "R8", "start of frame", sof, exp_sof);
                    if (exp_sof) armed_b = 0;
                    if (last_v >= 0)
                        chk((m - last_v) == (hi ? 16 : 32), hi ? "R4" : "R5",
                            "valid spacing", m - last_v, hi ? 16 : 32);
                    last_v = m;
                    last_out = {hs_o, vs_o, de_o, pix};
                end else begin
                    chk(sof == 1'b0, "R8", "sof without valid", sof, 0);
                    if (last_v >= 0)
                        chk({hs_o, vs_o, de_o, pix} == last_out, "R3", "hold between samples",
                            {hs_o, vs_o, de_o, pix}, last_out);
                end
            end
        end
        red = 4'($urandom); grn = 4'($urandom); blu = 4'($urandom);
        hs  = 1'($urandom);
        de  = de_en ? 1'($urandom) : 1'b0;
        vs  = vs_drv;
        hist[int'((m + 1) % 64)] = {hs, vs, de, red, grn, blu};
    endtask

    // Frame boundary: load new settings through a vsync pulse, checks paused.
    task automatic frame_sync(int s, int d, bit h);
        chk_en = 0; de_en = 0;
        repeat (20) step();
        cfg_st = TW'(s); cfg_dt = TW'(d); cfg_hi = h;
        vs_drv = 1;
        repeat (40) step();
        vs_drv = 0;
        ks = s; kd = d; hi = h; armed_b = 1;
        repeat (40) step();
        last_v = -1;
        chk_en = 1;
    endtask

    task automatic run(int n);
        repeat (30) step();
        de_en = 1;
        repeat (n) step();
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 64; i++) hist[i] = '0;
        repeat (6) step();
        // R9: reset state
        chk(pv == 1'b0, "R9", "valid in reset", pv, 0);
        chk(sof == 1'b0, "R9", "sof in reset", sof, 0);
        chk(pix == '0, "R9", "pixel in reset", pix, 0);
        chk(de_o == 1'b0, "R9", "de in reset", de_o, 0);
        chk(src_clk == 1'b0, "R9", "ref clock in reset", src_clk, 0);
        rst_n = 1'b1;
        frame_sync(3, 7, 1);
        run(600);
        // R7: new settings without a vsync must leave capture unchanged
        cfg_st = 4'd12; cfg_dt = 4'd1; cfg_hi = 1'b0;
        repeat (400) step();
        frame_sync(12, 1, 0);
        run(800);
        // R6: tap extremes in both directions
        frame_sync(15, 0, 1);
        run(400);
        frame_sync(0, 15, 0);
        run(800);
        frame_sync(0, 0, 1);
        run(400);
        for (int f = 0; f < 5; f++) begin
            frame_sync(int'($urandom % 16), int'($urandom % 16), 1'($urandom));
            run(500);
        end
        chk(checks > 500, "R2", "enough samples checked", checks, 500);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule